// File: doc/BRIEF.md
# Converter Fault Supervisor with Hiccup Restart

This block guards a digitally controlled step-down converter. Each clock it reads sampled codes for the bias rail, the input-sense divider, the die temperature, the feedback node and the soft-start level. From these it keeps four fault flags: bias undervoltage, input undervoltage, over-temperature and output short. Any one of them stops switching at once. It drops the gate-drive enable and pulls both active-low clamp requests, one for the soft-start node and one for the compensation node.

A fault also starts a fixed idle (hiccup) period counted in clock ticks. When the period ends, the converter restarts only if no fault flag is present. Supply and thermal faults therefore keep it parked until they go away. A short is judged against the lower of the soft-start level and the final reference. While idle the soft-start node is clamped, so that reference is low and the short flag drops by itself. A short that persists therefore gives one retry every period. Each restart releases the clamps so that a fresh soft-start ramp can begin.

Top module: `hiccup_fault_sup`

## Requirements
- R1: While reset is low and just after it is released, the block is idle: `fault_o`=1, `drv_en_o`=0, `ss_clamp_n_o`=0, `comp_clamp_n_o`=0. The idle period counts from the last reset edge.
- R2: The bias flag clears when `vbias_code` > BIAS_ON, sets when `vbias_code` < BIAS_OFF, and holds its value for codes between the two.
- R3: The input flag clears when `vin_code` > VIN_ON, sets when `vin_code` < VIN_OFF, and holds its value in between.
- R4: The thermal flag sets when `temp_code` >= OT_SET, clears when `temp_code` < OT_CLR, and holds in between.
- R5: The short flag is set when `fb_code` + SC_MARGIN < min(`ss_code`, VREF), compared without wrap.
- R6: Each flag is registered on the clock edge that samples its input. From that edge on, `fault_o`=1, `drv_en_o`=0 and both clamp requests are 0.
- R7: After an entry into idle on edge E, the earliest restart is edge E+IDLE_TICKS. A restart happens on the first edge from then on at which no flag is set.
- R8: A sustained short, with the soft-start node following its clamp, causes a repeated retry once per idle period.
- R9: `drv_en_o`, `ss_clamp_n_o` and `comp_clamp_n_o` are 1 only when `fault_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vbias_code | input | CODE_W | Bias rail sample |
| vin_code | input | CODE_W | Input-sense divider sample |
| temp_code | input | CODE_W | Die temperature sample |
| fb_code | input | CODE_W | Feedback node sample |
| ss_code | input | CODE_W | Soft-start node sample |
| fault_o | output | 1 | Master fault, 1 while idle or any flag set |
| drv_en_o | output | 1 | Gate-drive enable; 0 keeps both switches off |
| ss_clamp_n_o | output | 1 | Active-low soft-start clamp request |
| comp_clamp_n_o | output | 1 | Active-low compensation clamp request |

## Verification
Each rail is swept across both thresholds and into the gap between them. This separates a working hysteresis band from a single-threshold compare and from a flag that never clears. The feedback is placed exactly on and one code past the short margin, first at full reference and then part way up the soft-start ramp. This tells a strict compare from an inclusive one and shows whether the minimum of the two references is used. A held short with the soft-start node following its clamp counts the retries. A supply fault that stays past the idle period shows that restart waits for the flag to clear and not only for the timer.

// File: rtl/hfs_pkg.sv
// Shared types for the hiccup fault supervisor.
package hfs_pkg;
    typedef enum logic {
        HFS_IDLE = 1'b0,
        HFS_RUN  = 1'b1
    } hfs_state_t;
endpackage

// File: rtl/hfs_hyst_flag.sv
// Hysteretic threshold flag on one sampled code.
// SET_ABOVE=1: flag sets at code >= HI and clears below LO (over-limit).
// SET_ABOVE=0: flag clears above HI and sets below LO (undervoltage).
// Assumes LO <= HI. Between the two thresholds the flag holds.
module hfs_hyst_flag #(
    parameter int CODE_W    = 10,
    parameter int HI        = 425,
    parameter int LO        = 405,
    parameter bit SET_ABOVE = 1'b0,
    parameter bit RST_VAL   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic              flag
);
    localparam logic [CODE_W-1:0] HI_C = CODE_W'(HI);
    localparam logic [CODE_W-1:0] LO_C = CODE_W'(LO);

    logic set_c;
    logic clr_c;

    generate
        if (SET_ABOVE) begin : g_over
            // Over-limit: trip at or above HI, recover below LO.
            always_comb begin
                set_c = (code >= HI_C);
                clr_c = (code < LO_C);
            end
        end else begin : g_under
            // Undervoltage: trip below LO, recover above HI.
            always_comb begin
                set_c = (code < LO_C);
                clr_c = (code > HI_C);
            end
        end
    endgenerate

    // Flag register; the set condition wins over the clear condition.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag <= RST_VAL;
        else if (set_c) flag <= 1'b1;
        else if (clr_c) flag <= 1'b0;
    end
endmodule

// File: rtl/hfs_short_det.sv
// Output-short detector. Compares feedback with the active reference,
// which is the lower of the soft-start level and the final reference.
// Widened by one bit so the margin sum cannot wrap.
module hfs_short_det #(
    parameter int CODE_W    = 10,
    parameter int VREF      = 80,
    parameter int SC_MARGIN = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] fb_code,
    input  logic [CODE_W-1:0] ss_code,
    output logic              short_flag
);
    localparam int            EXT_W  = CODE_W + 1;
    localparam logic [CODE_W-1:0] VREF_C = CODE_W'(VREF);
    localparam logic [EXT_W-1:0]  MRG_C  = EXT_W'(SC_MARGIN);

    logic [CODE_W-1:0] ref_act;
    logic [EXT_W-1:0]  fb_plus;

    // Pick the active reference and lift feedback by the margin.
    always_comb begin
        ref_act = (ss_code < VREF_C) ? ss_code : VREF_C;
        fb_plus = {1'b0, fb_code} + MRG_C;
    end

    // Register the short decision once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) short_flag <= 1'b0;
        else        short_flag <= (fb_plus < {1'b0, ref_act});
    end
endmodule

// File: rtl/hfs_hiccup_ctl.sv
// Hiccup sequencer. Any fault flag moves RUN to IDLE and restarts the
// idle timer. IDLE lasts at least IDLE_TICKS edges and leaves only on an
// edge with no flag set (set-dominant over the timer's clear).
// Outputs drop in the same cycle a flag appears.
module hfs_hiccup_ctl #(
    parameter int IDLE_TICKS = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_flag,
    output logic fault_o,
    output logic drv_en_o,
    output logic ss_clamp_n_o,
    output logic comp_clamp_n_o
);
    import hfs_pkg::*;

    localparam int            CNT_W = (IDLE_TICKS > 2) ? $clog2(IDLE_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(IDLE_TICKS - 1);

    hfs_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             run_ok;

    // Sequencer state and idle timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= HFS_IDLE;
            cnt   <= '0;
        end else if (state == HFS_RUN) begin
            if (any_flag) begin
                state <= HFS_IDLE;
                cnt   <= '0;
            end
        end else if (cnt == LAST) begin
            if (!any_flag) state <= HFS_RUN;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Drive outputs; a present flag overrides the RUN state at once.
    always_comb begin
        run_ok         = (state == HFS_RUN) && !any_flag;
        fault_o        = !run_ok;
        drv_en_o       = run_ok;
        ss_clamp_n_o   = run_ok;
        comp_clamp_n_o = run_ok;
    end
endmodule

// File: rtl/hiccup_fault_sup.sv
// Top of the converter fault supervisor: two hysteretic undervoltage
// flags, one hysteretic thermal flag, a short detector against the
// moving reference, and the hiccup sequencer. All thresholds are codes
// in the units of the matching input sample.
module hiccup_fault_sup #(
    parameter int CODE_W     = 10,
    parameter int BIAS_ON    = 425,
    parameter int BIAS_OFF   = 405,
    parameter int VIN_ON     = 250,
    parameter int VIN_OFF    = 220,
    parameter int OT_SET     = 145,
    parameter int OT_CLR     = 135,
    parameter int VREF       = 80,
    parameter int SC_MARGIN  = 25,
    parameter int CLK_HZ     = 100_000_000,
    parameter int IDLE_TICKS = CLK_HZ / 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] vbias_code,
    input  logic [CODE_W-1:0] vin_code,
    input  logic [CODE_W-1:0] temp_code,
    input  logic [CODE_W-1:0] fb_code,
    input  logic [CODE_W-1:0] ss_code,
    output logic              fault_o,
    output logic              drv_en_o,
    output logic              ss_clamp_n_o,
    output logic              comp_clamp_n_o
);
    logic uv_bias;
    logic uv_in;
    logic over_temp;
    logic short_out;
    logic any_flag;

    hfs_hyst_flag #(.CODE_W(CODE_W), .HI(BIAS_ON), .LO(BIAS_OFF),
                    .SET_ABOVE(1'b0), .RST_VAL(1'b1)) u_bias (
        .clk(clk), .rst_n(rst_n), .code(vbias_code), .flag(uv_bias));

    hfs_hyst_flag #(.CODE_W(CODE_W), .HI(VIN_ON), .LO(VIN_OFF),
                    .SET_ABOVE(1'b0), .RST_VAL(1'b1)) u_vin (
        .clk(clk), .rst_n(rst_n), .code(vin_code), .flag(uv_in));

    hfs_hyst_flag #(.CODE_W(CODE_W), .HI(OT_SET), .LO(OT_CLR),
                    .SET_ABOVE(1'b1), .RST_VAL(1'b0)) u_temp (
        .clk(clk), .rst_n(rst_n), .code(temp_code), .flag(over_temp));

    hfs_short_det #(.CODE_W(CODE_W), .VREF(VREF), .SC_MARGIN(SC_MARGIN)) u_short (
        .clk(clk), .rst_n(rst_n), .fb_code(fb_code), .ss_code(ss_code),
        .short_flag(short_out));

    // Merge all flags into the single fault request.
    always_comb any_flag = uv_bias | uv_in | over_temp | short_out;

    hfs_hiccup_ctl #(.IDLE_TICKS(IDLE_TICKS)) u_ctl (
        .clk(clk), .rst_n(rst_n), .any_flag(any_flag),
        .fault_o(fault_o), .drv_en_o(drv_en_o),
        .ss_clamp_n_o(ss_clamp_n_o), .comp_clamp_n_o(comp_clamp_n_o));
endmodule

// File: rtl/hfs_checker.sv
// Property checker for hiccup_fault_sup, attached by bind below.
// Watches the ports only; the idle window is measured by a local counter.
module hfs_checker #(
    parameter int CODE_W     = 10,
    parameter int BIAS_OFF   = 405,
    parameter int VIN_OFF    = 220,
    parameter int OT_SET     = 145,
    parameter int VREF       = 80,
    parameter int SC_MARGIN  = 25,
    parameter int IDLE_TICKS = 10_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] vbias_code,
    input logic [CODE_W-1:0] vin_code,
    input logic [CODE_W-1:0] temp_code,
    input logic [CODE_W-1:0] fb_code,
    input logic [CODE_W-1:0] ss_code,
    input logic              fault_o,
    input logic              drv_en_o,
    input logic              ss_clamp_n_o,
    input logic              comp_clamp_n_o
);
    localparam int W = 32;
    logic [W-1:0] off_cnt;
    int           ref_min;
    logic         short_now;

    // Count edges spent with the drive disabled, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)          off_cnt <= '0;
        else if (drv_en_o)   off_cnt <= '0;
        else if (off_cnt != '1) off_cnt <= off_cnt + 1'b1;
    end

    // Short condition as seen at the ports.
    always_comb begin
        ref_min   = (int'(ss_code) < VREF) ? int'(ss_code) : VREF;
        short_now = (int'(fb_code) + SC_MARGIN) < ref_min;
    end

    AST_BIAS_LOW_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(vbias_code) < BIAS_OFF) |=> fault_o);                     // R2
    AST_VIN_LOW_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(vin_code) < VIN_OFF) |=> fault_o);                        // R3
    AST_HOT_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(temp_code) >= OT_SET) |=> (fault_o && !drv_en_o));        // R4
    AST_SHORT_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
        short_now |=> !drv_en_o);                                       // R5
    AST_CLAMPS_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en_o |-> (!ss_clamp_n_o && !comp_clamp_n_o));              // R6
    AST_IDLE_LONG_ENOUGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en_o) |-> (off_cnt >= W'(IDLE_TICKS)));               // R7
    AST_DRIVE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (!drv_en_o && !ss_clamp_n_o && !comp_clamp_n_o));   // R9
endmodule

bind hiccup_fault_sup hfs_checker #(
    .CODE_W(CODE_W), .BIAS_OFF(BIAS_OFF), .VIN_OFF(VIN_OFF),
    .OT_SET(OT_SET), .VREF(VREF), .SC_MARGIN(SC_MARGIN),
    .IDLE_TICKS(IDLE_TICKS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .vbias_code(vbias_code), .vin_code(vin_code),
    .temp_code(temp_code), .fb_code(fb_code), .ss_code(ss_code),
    .fault_o(fault_o), .drv_en_o(drv_en_o), .ss_clamp_n_o(ss_clamp_n_o),
    .comp_clamp_n_o(comp_clamp_n_o)
);

// File: tb/hiccup_fault_sup_tb.sv
// Bench: behavioural reference model updated on each rising edge and
// compared with all outputs on each falling edge; inputs change 1 ns
// after the falling edge.
module hiccup_fault_sup_tb;
    localparam int CW = 8;
    localparam int B_ON = 170, B_OFF = 162, V_ON = 100, V_OFF = 88;
    localparam int T_SET = 145, T_CLR = 135, REF = 80, MRG = 25, TICKS = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] vbias_code = '0, vin_code = '0, temp_code = '0;
    logic [CW-1:0] fb_code = '0, ss_code = '0;
    logic fault_o, drv_en_o, ss_clamp_n_o, comp_clamp_n_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    hiccup_fault_sup #(
        .CODE_W(CW), .BIAS_ON(B_ON), .BIAS_OFF(B_OFF), .VIN_ON(V_ON),
        .VIN_OFF(V_OFF), .OT_SET(T_SET), .OT_CLR(T_CLR), .VREF(REF),
        .SC_MARGIN(MRG), .CLK_HZ(160), .IDLE_TICKS(TICKS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .vbias_code(vbias_code), .vin_code(vin_code),
        .temp_code(temp_code), .fb_code(fb_code), .ss_code(ss_code),
        .fault_o(fault_o), .drv_en_o(drv_en_o), .ss_clamp_n_o(ss_clamp_n_o),
        .comp_clamp_n_o(comp_clamp_n_o)
    );

    // Reference model state
    bit m_ub = 1, m_ui = 1, m_ot = 0, m_sc = 0, m_run = 0;
    int m_k = 0;

    always @(posedge clk) begin
        bit any_old;
        int r;
        if (!rst_n) begin
            m_ub = 1; m_ui = 1; m_ot = 0; m_sc = 0; m_run = 0; m_k = 0;
        end else begin
            any_old = m_ub | m_ui | m_ot | m_sc;
            if (m_run) begin
                if (any_old) begin m_run = 0; m_k = 0; end
            end else begin
                m_k = m_k + 1;
                if (m_k >= TICKS && !any_old) m_run = 1;
            end
            if (int'(vbias_code) > B_ON) m_ub = 0;
            if (int'(vbias_code) < B_OFF) m_ub = 1;
            if (int'(vin_code) > V_ON) m_ui = 0;
            if (int'(vin_code) < V_OFF) m_ui = 1;
            if (int'(temp_code) < T_CLR) m_ot = 0;
            if (int'(temp_code) >= T_SET) m_ot = 1;
            r = (int'(ss_code) < REF) ? int'(ss_code) : REF;
            m_sc = (int'(fb_code) + MRG) < r;
        end
    end

    // Cycle compare against the model
    always @(negedge clk) begin
        bit ok;
        bit e_run;
        if (!finished) begin
            e_run = m_run && !(m_ub | m_ui | m_ot | m_sc);
            ok = (fault_o === !e_run) && (drv_en_o === e_run) &&
                 (ss_clamp_n_o === e_run) && (comp_clamp_n_o === e_run);
            n_chk++;
            if (!ok) begin
                n_bad++;
                $display("FAIL R6 R7 R9 cycle compare @%0t: fault/drv/ssn/compn=%b%b%b%b expected %b%b%b%b",
                         $time, fault_o, drv_en_o, ss_clamp_n_o, comp_clamp_n_o,
                         !e_run, e_run, e_run, e_run);
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic good_inputs();
        vbias_code = 8'd200; vin_code = 8'd150; temp_code = 8'd25;
        fb_code = 8'd80; ss_code = 8'd80;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int rises;
        bit prev;
        good_inputs();
        step(3);
        // R1: reset state
        chk("R1 fault in reset", fault_o, 1'b1);
        chk("R1 drive off in reset", drv_en_o, 1'b0);
        chk("R1 ss clamp in reset", ss_clamp_n_o, 1'b0);
        rst_n = 1'b1;
        step(1);
        chk("R1 comp clamp after reset", comp_clamp_n_o, 1'b0);
        step(TICKS + 2);
        chk("R7 restart after idle", drv_en_o, 1'b1);

        // R2: bias hysteresis
        vbias_code = 8'd165; step(3);
        chk("R2 hold in band while running", drv_en_o, 1'b1);
        vbias_code = 8'd161; step(1);
        chk("R2 trip below off", fault_o, 1'b1);
        chk("R6 clamp at trip", ss_clamp_n_o, 1'b0);
        vbias_code = 8'd165; step(TICKS + 4);
        chk("R2 R7 hold fault in band past idle", drv_en_o, 1'b0);
        vbias_code = 8'd171; step(2);
        chk("R7 restart once flag clears", drv_en_o, 1'b1);

        // R3: input hysteresis
        vin_code = 8'd87; step(2);
        chk("R3 trip below off", fault_o, 1'b1);
        vin_code = 8'd100; step(TICKS + 3);
        chk("R3 hold at on threshold", drv_en_o, 1'b0);
        vin_code = 8'd101; step(2);
        chk("R3 release above on", drv_en_o, 1'b1);

        // R4: thermal hysteresis
        temp_code = 8'd144; step(2);
        chk("R4 no trip below set", drv_en_o, 1'b1);
        temp_code = 8'd145; step(1);
        chk("R4 trip at set", fault_o, 1'b1);
        temp_code = 8'd135; step(TICKS + 3);
        chk("R4 hold at clear code", drv_en_o, 1'b0);
        temp_code = 8'd134; step(2);
        chk("R4 release below clear", drv_en_o, 1'b1);

        // R5: short boundaries at full reference
        fb_code = 8'd55; step(3);
        chk("R5 no short at margin", drv_en_o, 1'b1);
        fb_code = 8'd54; step(1);
        chk("R5 short past margin", fault_o, 1'b1);
        fb_code = 8'd80; step(TICKS + 2);
        chk("R5 recover after short", drv_en_o, 1'b1);

        // R5: short during soft start uses the ramp level
        ss_code = 8'd40; fb_code = 8'd15; step(3);
        chk("R5 no short at ramp margin", drv_en_o, 1'b1);
        fb_code = 8'd14; step(1);
        chk("R5 short against ramp", fault_o, 1'b1);
        good_inputs(); step(TICKS + 2);
        chk("R5 recover after ramp short", drv_en_o, 1'b1);

        // R8: sustained short, soft-start follows its clamp
        fb_code = 8'd0;
        rises = 0;
        prev = drv_en_o;
        for (int i = 0; i < 4 * (TICKS + 3); i++) begin
            ss_code = ss_clamp_n_o ? 8'd80 : 8'd0;
            step(1);
            if (drv_en_o && !prev) rises++;
            prev = drv_en_o;
        end
        n_chk++;
        if (rises < 3) begin
            n_bad++;
            $display("FAIL R8 retries: actual %0d expected at least 3", rises);
        end
        good_inputs(); step(TICKS + 4);
        chk("R9 clean run after retries", fault_o, 1'b0);
        finish_run();
    end
endmodule